// File: doc/BRIEF.md
# Local exclusive access monitor

This block sits next to one processor core and decides whether that core's conditional (exclusive) stores may write. An exclusive load opens a reservation on the 8-byte aligned granule that holds its address. A later exclusive store succeeds only while that reservation is still open. The monitor holds exactly one reservation at a time. A newer exclusive load moves the reservation to its own granule. The reservation is dropped by any exclusive store, whether it passes or fails. It is also dropped by an ordinary store from the same core that touches the granule, by a clear command on the request port, and by a separate clear pin meant for context switches.

Requests arrive on a valid/ready port. A request is taken on a rising edge where both `req_valid` and `req_ready` are high. Each accepted exclusive store produces one status beat on a valid/ready response port in the next cycle, with 0 meaning success and 1 meaning failure. The response is held in a single register. While `rsp_valid` is high and `rsp_ready` is low, the beat and its status stay unchanged and `req_ready` is low, so no further request is taken until the beat has been consumed. Loads, plain stores and clears produce no response.

A parameter selects one of two modes. In checking mode the granule of an exclusive store must equal the reserved granule. In relaxed mode any exclusive store matches an open reservation.

Top module: `xmon_local`

## Requirements
- R1: After reset no reservation is open, `rsp_valid` is low and `req_ready` is high; a first exclusive store fails with status 1.
- R2: An exclusive load (op code 0) followed by an exclusive store (op code 1) whose address lies in the same 8-byte aligned granule (address bits above bit 2 equal) returns status 0.
- R3: In checking mode an exclusive store to a different granule than the reserved one returns status 1.
- R4: A second exclusive load replaces the reservation, so a store to the first granule fails in checking mode while one to the second succeeds.
- R5: Every accepted exclusive store closes the reservation, so an immediately following exclusive store to the same granule returns status 1.
- R6: A plain store (op code 2) of 2^size bytes starting at its address closes the reservation when any of its bytes falls inside the reserved granule, and leaves it open otherwise.
- R7: A clear request (op code 3) or a high `clear_excl` closes the reservation; when `clear_excl` is high in the same cycle as an accepted exclusive load, no reservation is left open.
- R8: In relaxed mode an exclusive store returns status 0 whenever a reservation is open, whatever its address, and 1 when none is open.
- R9: The status of an exclusive store accepted on one edge appears with `rsp_valid` high after the next edge; other op codes raise no response.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_status` hold and `req_ready` is low; a request offered in that time is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 2 | 0 exclusive load, 1 exclusive store, 2 plain store, 3 clear |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | SIZE_W | Access size as log2 of the byte count |
| clear_excl | input | 1 | Drop any reservation (context switch) |
| rsp_valid | output | 1 | Status beat for an exclusive store |
| rsp_ready | input | 1 | Consumer takes the status beat |
| rsp_status | output | 1 | 0 store may write, 1 store failed |

## Verification
Load/exclusive-store address pairs are swept across a small address space on a checking-mode and a relaxed-mode instance side by side. This separates a granule comparison from a byte or word comparison, and separates the two modes. Plain stores of every size are swept around a reserved granule, which tells an overlap test from a start-address test, including stores that begin in the granule before and spill into it. Directed sequences cover replacement, back-to-back exclusive stores, both clear paths and the clear/load collision. A stalled response tells whether the beat is held and new requests are refused.

// File: rtl/xmon_pkg.sv
package xmon_pkg;

  typedef enum logic [1:0] {
    OP_LDEX  = 2'd0,
    OP_STEX  = 2'd1,
    OP_ST    = 2'd2,
    OP_CLREX = 2'd3
  } xmon_op_e;

  localparam logic STAT_PASS = 1'b0;
  localparam logic STAT_FAIL = 1'b1;

endpackage

// File: rtl/xmon_gran_cmp.sv
module xmon_gran_cmp #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 2,
  parameter int GRAN_LG = 3,
  parameter bit RELAXED = 1'b0
) (
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [SIZE_W-1:0]         req_size,
  input  logic [ADDR_W-GRAN_LG-1:0] tag_gran,
  output logic [ADDR_W-GRAN_LG-1:0] first_gran,
  output logic                      stex_hit,
  output logic                      st_hit
);
  localparam int GW = ADDR_W - GRAN_LG;
  localparam int OW = GRAN_LG + 1;
  localparam logic [OW-1:0] GRAN_LAST = OW'((1 << GRAN_LG) - 1);

  logic [OW-1:0] span;
  logic [OW-1:0] offs_end;
  logic          crosses;
  logic [GW-1:0] last_gran;

  always_comb begin
    first_gran = req_addr[ADDR_W-1:GRAN_LG];
    span       = OW'((1 << req_size) - 1);
    offs_end   = {1'b0, req_addr[GRAN_LG-1:0]} + span;
    crosses    = offs_end > GRAN_LAST;
    last_gran  = first_gran + GW'(crosses);
    st_hit     = (first_gran == tag_gran) || (last_gran == tag_gran);
  end

  generate
    if (RELAXED) begin : g_relaxed
      assign stex_hit = 1'b1;
    end else begin : g_checked
      assign stex_hit = (first_gran == tag_gran);
    end
  endgenerate

endmodule

// File: rtl/xmon_tag.sv
module xmon_tag #(
  parameter int GW = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  xmon_pkg::xmon_op_e   op,
  input  logic [GW-1:0]        new_gran,
  input  logic                 st_hit,
  input  logic                 clr_pin,
  output logic                 tag_valid,
  output logic [GW-1:0]        tag_gran
);
  import xmon_pkg::*;

  logic          valid_nx;
  logic [GW-1:0] gran_nx;
  logic          clr_any;

  always_comb begin
    clr_any  = clr_pin || (fire && op == OP_CLREX);
    valid_nx = tag_valid;
    gran_nx  = tag_gran;
    if (clr_any) begin
      valid_nx = 1'b0;
    end else if (fire) begin
      unique case (op)
        OP_LDEX: begin
          valid_nx = 1'b1;
          gran_nx  = new_gran;
        end
        OP_STEX: valid_nx = 1'b0;
        OP_ST:   if (st_hit) valid_nx = 1'b0;
        default: valid_nx = tag_valid;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_valid <= 1'b0;
      tag_gran  <= '0;
    end else begin
      tag_valid <= valid_nx;
      tag_gran  <= gran_nx;
    end
  end

endmodule

// File: rtl/xmon_rsp.sv
module xmon_rsp (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic status_in,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_status,
  output logic slot_free
);
  assign slot_free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= xmon_pkg::STAT_FAIL;
    end else if (slot_free) begin
      rsp_valid <= load;
      if (load) rsp_status <= status_in;
    end
  end

endmodule

// File: rtl/xmon_local.sv
module xmon_local #(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 2,
  parameter int GRAN_LG = 3,
  parameter bit RELAXED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              clear_excl,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_status
);
  import xmon_pkg::*;

  localparam int GW = ADDR_W - GRAN_LG;

  xmon_op_e      op;
  logic          fire;
  logic          tag_valid;
  logic [GW-1:0] tag_gran;
  logic [GW-1:0] first_gran;
  logic          stex_hit;
  logic          st_hit;
  logic          stex_fire;
  logic          stex_status;

  assign op          = xmon_op_e'(req_op);
  assign fire        = req_valid && req_ready;
  assign stex_fire   = fire && (op == OP_STEX);
  assign stex_status = (tag_valid && stex_hit) ? STAT_PASS : STAT_FAIL;

  xmon_gran_cmp #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .GRAN_LG(GRAN_LG),
    .RELAXED(RELAXED)
  ) u_cmp (
    .req_addr  (req_addr),
    .req_size  (req_size),
    .tag_gran  (tag_gran),
    .first_gran(first_gran),
    .stex_hit  (stex_hit),
    .st_hit    (st_hit)
  );

  xmon_tag #(.GW(GW)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .op       (op),
    .new_gran (first_gran),
    .st_hit   (st_hit),
    .clr_pin  (clear_excl),
    .tag_valid(tag_valid),
    .tag_gran (tag_gran)
  );

  xmon_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (stex_fire),
    .status_in (stex_status),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_status(rsp_status),
    .slot_free (req_ready)
  );

endmodule

// File: rtl/xmon_local_chk.sv
module xmon_local_chk #(
  parameter bit RELAXED = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       clear_excl,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic       rsp_status,
  input logic       tag_valid
);
  logic acc;
  logic stalled;
  assign acc     = req_valid && req_ready;
  assign stalled = rsp_valid && !rsp_ready;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> rsp_valid && $stable(rsp_status));

  assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !req_ready);

  assert_rsp_after_stex_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd1) |=> rsp_valid);

  assert_no_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && req_op == 2'd1) && !stalled) |=> !rsp_valid);

  assert_stex_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd1) |=> !tag_valid);

  assert_pin_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_excl |=> !tag_valid);

  assert_no_tag_fail_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == 2'd1 && !tag_valid) |=> rsp_status);

  assert_relaxed_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (RELAXED && acc && req_op == 2'd1 && tag_valid) |=> !rsp_status);

endmodule

bind xmon_local xmon_local_chk #(.RELAXED(RELAXED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .clear_excl(clear_excl),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_status(rsp_status),
  .tag_valid (tag_valid)
);

// File: tb/xmon_local_test.sv
module xmon_local_test;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd0;
  logic clear_excl = 1'b0;
  logic rsp_ready = 1'b1;
  logic rdy_c, rdy_r, vld_c, vld_r, st_c, st_r;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xmon_local #(.ADDR_W(AW), .SIZE_W(2), .GRAN_LG(3), .RELAXED(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_c),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .clear_excl(clear_excl), .rsp_valid(vld_c), .rsp_ready(rsp_ready),
    .rsp_status(st_c));

  xmon_local #(.ADDR_W(AW), .SIZE_W(2), .GRAN_LG(3), .RELAXED(1'b1)) uut_relaxed (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_r),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .clear_excl(clear_excl), .rsp_valid(vld_r), .rsp_ready(rsp_ready),
    .rsp_status(st_r));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue one request at a falling edge; returns at the next falling edge.
  task automatic issue(input logic [1:0] op, input int a, input int sz);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = AW'(a);
    req_size  = 2'(sz);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic stex_expect(input int a, input int exp_c, input int exp_r, input string req);
    issue(2'd1, a, 0);
    check(vld_c && st_c == exp_c[0], req, {vld_c, st_c}, {1'b1, exp_c[0]});
    check(vld_r && st_r == exp_r[0], req, {vld_r, st_r}, {1'b1, exp_r[0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and first exclusive store
    check(!vld_c && rdy_c, "R1", {vld_c, rdy_c}, 1);
    check(!vld_r && rdy_r, "R1", {vld_r, rdy_r}, 1);
    stex_expect(0, 1, 1, "R1");

    // R9: loads, plain stores and clears raise no response
    issue(2'd0, 16, 0);
    check(!vld_c && !vld_r, "R9", vld_c, 0);
    issue(2'd2, 100, 0);
    check(!vld_c && !vld_r, "R9", vld_c, 0);
    issue(2'd3, 0, 0);
    check(!vld_c && !vld_r, "R9", vld_c, 0);

    // R2 R3 R8: sweep load/store address pairs
    for (int la = 0; la < 256; la += 3) begin
      for (int sa = 0; sa < 256; sa += 11) begin
        issue(2'd0, la, 0);
        stex_expect(sa, ((la >> 3) == (sa >> 3)) ? 0 : 1, 0,
                    ((la >> 3) == (sa >> 3)) ? "R2" : "R3_R8");
      end
    end

    // R5: second exclusive store after a pass fails in both modes
    issue(2'd0, 40, 0);
    stex_expect(44, 0, 0, "R5");
    stex_expect(44, 1, 1, "R5");

    // R4: replacement by a newer exclusive load
    issue(2'd0, 40, 0);
    issue(2'd0, 80, 0);
    stex_expect(40, 1, 0, "R4");
    issue(2'd0, 40, 0);
    issue(2'd0, 80, 0);
    stex_expect(87, 0, 0, "R4");

    // R6: plain store overlap sweep around granule 40..47
    for (int a = 24; a < 64; a++) begin
      for (int s = 0; s < 4; s++) begin
        int last;
        bit ovl;
        last = a + (1 << s) - 1;
        ovl  = (last >= 40) && (a <= 47);
        issue(2'd0, 42, 0);
        issue(2'd2, a, s);
        stex_expect(40, ovl ? 1 : 0, ovl ? 1 : 0, "R6");
      end
    end

    // R7: clear op, clear pin, and pin colliding with a load
    issue(2'd0, 8, 0);
    issue(2'd3, 200, 0);
    stex_expect(8, 1, 1, "R7");
    issue(2'd0, 8, 0);
    clear_excl = 1'b1;
    @(negedge clk);
    clear_excl = 1'b0;
    stex_expect(8, 1, 1, "R7");
    clear_excl = 1'b1;
    issue(2'd0, 8, 0);
    clear_excl = 1'b0;
    stex_expect(8, 1, 1, "R7");

    // R10: stalled response
    issue(2'd0, 16, 0);
    rsp_ready = 1'b0;
    issue(2'd1, 16, 0);
    check(vld_c && !st_c, "R10", {vld_c, st_c}, 2);
    req_valid = 1'b1;
    req_op    = 2'd1;
    req_addr  = AW'(16);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(vld_c && !st_c && !rdy_c, "R10", {vld_c, st_c, rdy_c}, 4);
      check(vld_r && !st_r && !rdy_r, "R10", {vld_r, st_r, rdy_r}, 4);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(vld_c && st_c, "R10", {vld_c, st_c}, 3);
    check(vld_r && st_r, "R10", {vld_r, st_r}, 3);
    @(negedge clk);
    check(!vld_c && !vld_r, "R9", vld_c, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule